// File: doc/BRIEF.md
# Iterative SM4 Block Cipher Core

This core encrypts or decrypts one 128-bit block under a 128-bit key with the SM4 algorithm. A caller presents the key, the block and a direction bit, then pulses `start_i` while the core is idle. The core first builds the full 32-word round-key schedule, one word per cycle, into a small register file. It then applies the 32 cipher rounds, one per cycle, through the same nonlinear stage. Decryption runs the identical round datapath and reads the stored schedule from the top down.

The result appears on `result_o` together with a one-cycle `done_o` pulse. It holds there until the next block completes. `busy_o` covers the whole run. While it is high the core ignores `start_i` and no longer looks at its key, data or direction inputs. A new block may be started in the very cycle that `done_o` is high.

Top module: `sm4_iter_core`

## Requirements
- R1: After a synchronous active-low reset, `busy_o` and `done_o` are 0 and `result_o` is all zeros.
- R2: With `decrypt_i` = 0 the result is the SM4 encryption of `block_i` under `key_i`. Input words are big-endian, with word 0 at bits [127:96]. The output places x35 at [127:96], x34 at [95:64], x33 at [63:32] and x32 at [31:0]. For example, key = block = 0123456789abcdeffedcba9876543210 gives 681edf34d206965e86b3e94f536e4246.
- R3: Key schedule setup XORs key word n with A3B1BAC6, 56AA3350, 677D9197, B27022DC for n = 0..3. Each step then computes k[i+4] = k[i] ^ T'(k[i+1]^k[i+2]^k[i+3]^CK[i]), where byte j of CK[i] (byte 0 most significant) is ((4i+j)*7) mod 256. T' is the S-box on each byte followed by y ^ rol(y,13) ^ rol(y,23). Round key i is k[i+4].
- R4: Each round computes x[i+4] = x[i] ^ T(x[i+1]^x[i+2]^x[i+3]^rk). T is the byte S-box followed by y ^ rol(y,2) ^ rol(y,10) ^ rol(y,18) ^ rol(y,24). The S-box is S(v) = C ^ A·inv(A·v ^ C). Here inv is the inverse in GF(2^8) modulo 0x1F5, with inv(0) = 0, and C = 0xD3. Output bit r of A·v is the parity of v AND (0xA7 rotated left by r).
- R5: With `decrypt_i` = 1, round i uses round key 31−i, so decrypting a ciphertext under the same key returns the plaintext.
- R6: `start_i` is accepted on a rising edge only while `busy_o` is 0. `busy_o` is 1 from the next cycle until the result is delivered.
- R7: `done_o` is high for exactly one cycle, 64 cycles after the accepting edge (32 schedule steps plus 32 rounds). `busy_o` falls in the same cycle.
- R8: A `start_i` pulse while `busy_o` is 1 has no effect: no extra result, and no change to the running block's result or timing.
- R9: `key_i`, `block_i` and `decrypt_i` are sampled only on the accepting edge. Changes to them during a run do not alter its result.
- R10: `result_o` changes only in a cycle where `done_o` is high and otherwise holds its value.
- R11: A start in the cycle where `done_o` is high is accepted, so blocks can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a block when idle |
| decrypt_i | input | 1 | 1 = decrypt, 0 = encrypt |
| key_i | input | 128 | Cipher key, big-endian words |
| block_i | input | 128 | Input block, big-endian words |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 128 | Last completed block result |

## Verification
The checker watches the control behaviour on every cycle:
- the exact 64-cycle distance from an accepted start to `done_o`;
- the single-cycle width of `done_o`;
- `busy_o` rising after acceptance and staying high for the whole run;
- `busy_o` falling only together with `done_o`;
- `result_o` holding between completions;
- the reset state.

Whether the result is the correct SM4 value can only be shown by the bench scenarios. These are a published encrypt vector, decryption back to the plaintext, and all-zero, all-one and varied keys against an independent model. The scenarios also cover ignored starts with the inputs changed during a run, and back-to-back blocks.

// File: rtl/sm4_core_pkg.sv
// Shared constants, types and elaboration-time helpers for the SM4 core.
// Assumes SM4's fixed 32-bit word and 128-bit block; the S-box table is
// generated from its field-inverse definition rather than written out.
package sm4_core_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int WORDS   = 4;
    localparam int BLOCK_W = WORD_W * WORDS;
    localparam int SBOX_N  = 1 << BYTE_W;

    localparam logic [BYTE_W-1:0] FIELD_RED  = 8'hF5;   // x^8 = x^7+x^6+x^5+x^4+x^2+1
    localparam logic [BYTE_W-1:0] AFF_ROW    = 8'hA7;
    localparam logic [BYTE_W-1:0] AFF_CONST  = 8'hD3;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SCHED  = 2'd1,
        PH_ROUND  = 2'd2
    } phase_e;

    // Multiply two field elements modulo the S-box polynomial.
    function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                                 input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[BYTE_W-1] ? ({sh[BYTE_W-2:0], 1'b0} ^ FIELD_RED)
                              : {sh[BYTE_W-2:0], 1'b0};
        end
        return acc;
    endfunction

    // Field inverse as a^254 (maps 0 to 0).
    function automatic logic [BYTE_W-1:0] gf_inv(input logic [BYTE_W-1:0] a);
        logic [BYTE_W-1:0] pw;
        logic [BYTE_W-1:0] acc;
        pw  = gf_mul(a, a);
        acc = pw;
        for (int i = 0; i < 6; i++) begin
            pw  = gf_mul(pw, pw);
            acc = gf_mul(acc, pw);
        end
        return acc;
    endfunction

    // Affine step: output bit r is parity of v with the row mask rotated by r.
    function automatic logic [BYTE_W-1:0] affine(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] row;
        logic [BYTE_W-1:0] o;
        row = AFF_ROW;
        for (int r = 0; r < BYTE_W; r++) begin
            o[r] = ^(v & row);
            row  = {row[BYTE_W-2:0], row[BYTE_W-1]};
        end
        return o ^ AFF_CONST;
    endfunction

    // Build the packed 256-entry substitution table at elaboration.
    function automatic logic [SBOX_N*BYTE_W-1:0] build_sbox();
        logic [SBOX_N*BYTE_W-1:0] t;
        for (int i = 0; i < SBOX_N; i++)
            t[i*BYTE_W +: BYTE_W] = affine(gf_inv(affine(BYTE_W'(i))));
        return t;
    endfunction

    localparam logic [SBOX_N*BYTE_W-1:0] SBOX_TABLE = build_sbox();

    // Key-schedule constant: byte j (MSB first) is (4*idx+j)*7 mod 256.
    function automatic word_t ck_word(input int idx);
        word_t w;
        for (int j = 0; j < WORDS; j++)
            w[WORD_W-1-j*BYTE_W -: BYTE_W] = BYTE_W'((WORDS*idx + j) * 7);
        return w;
    endfunction

    // Whitening constant applied to key word n before the schedule.
    function automatic word_t fk_word(input int n);
        case (n)
            0:       return 32'hA3B1BAC6;
            1:       return 32'h56AA3350;
            2:       return 32'h677D9197;
            default: return 32'hB27022DC;
        endcase
    endfunction

    // Rotate a word left by a constant amount.
    function automatic word_t rol32(input word_t x, input int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

endpackage

// File: rtl/sm4_sbox_word.sv
// Applies the byte substitution to each of the four bytes of a word.
// Purely combinational lookup into the elaboration-time table.
module sm4_sbox_word
    import sm4_core_pkg::*;
(
    input  word_t din,
    output word_t dout
);

    // One table lookup per byte lane.
    for (genvar b = 0; b < WORDS; b++) begin : g_lane
        assign dout[b*BYTE_W +: BYTE_W] =
            SBOX_TABLE[{din[b*BYTE_W +: BYTE_W], 3'b000} +: BYTE_W];
    end

endmodule

// File: rtl/sm4_lin_mix.sv
// Linear diffusion after the S-box. KEY_SCHED picks the key-schedule
// transform (rotations 13, 23) or the round transform (2, 10, 18, 24).
module sm4_lin_mix
    import sm4_core_pkg::*;
#(
    parameter bit KEY_SCHED = 1'b0
)
(
    input  word_t din,
    output word_t dout
);

    // Variant chosen at elaboration.
    if (KEY_SCHED) begin : g_key
        assign dout = din ^ rol32(din, 13) ^ rol32(din, 23);
    end else begin : g_data
        assign dout = din ^ rol32(din, 2) ^ rol32(din, 10)
                          ^ rol32(din, 18) ^ rol32(din, 24);
    end

endmodule

// File: rtl/sm4_rkey_file.sv
// Round-key storage: one write port, one combinational read port.
// Not reset: every entry is written during the schedule phase before any
// round reads it.
module sm4_rkey_file
    import sm4_core_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
)
(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);

    word_t mem_q [DEPTH];

    // Store a freshly derived round key.
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sm4_iter_core.sv
// Iterative SM4 core. On an accepted start it runs ROUNDS key-schedule
// steps into the round-key file, then ROUNDS cipher rounds, sharing one
// S-box stage between both phases. Assumes ROUNDS = 32 for standard SM4.
module sm4_iter_core
    import sm4_core_pkg::*;
#(
    parameter int ROUNDS = 32
)
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         decrypt_i,
    input  logic [127:0] key_i,
    input  logic [127:0] block_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [127:0] result_o
);

    localparam int CNT_W = $clog2(ROUNDS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              dec_q;
    logic              done_q;
    logic [127:0]      result_q;
    word_t             kwin_q [WORDS];
    word_t             xwin_q [WORDS];

    word_t             ck_cur;
    word_t             mix_in;
    word_t             sub_out;
    word_t             key_lin;
    word_t             dat_lin;
    word_t             k_next;
    word_t             x_next;
    word_t             rk_rd;
    logic [CNT_W-1:0]  rk_raddr;
    logic              accept;
    logic              last_step;

    assign accept    = (phase_q == PH_IDLE) && start_i;
    assign last_step = (cnt_q == LAST);
    assign ck_cur    = ck_word(int'(cnt_q));

    // Select the word fed to the shared nonlinear stage for this phase.
    always_comb begin
        if (phase_q == PH_SCHED)
            mix_in = kwin_q[1] ^ kwin_q[2] ^ kwin_q[3] ^ ck_cur;
        else
            mix_in = xwin_q[1] ^ xwin_q[2] ^ xwin_q[3] ^ rk_rd;
    end

    sm4_sbox_word u_sbox (
        .din  (mix_in),
        .dout (sub_out)
    );

    sm4_lin_mix #(.KEY_SCHED(1'b1)) u_lin_key (
        .din  (sub_out),
        .dout (key_lin)
    );

    sm4_lin_mix #(.KEY_SCHED(1'b0)) u_lin_dat (
        .din  (sub_out),
        .dout (dat_lin)
    );

    assign k_next   = kwin_q[0] ^ key_lin;
    assign x_next   = xwin_q[0] ^ dat_lin;
    assign rk_raddr = dec_q ? (LAST - cnt_q) : cnt_q;

    sm4_rkey_file #(.DEPTH(ROUNDS)) u_rkeys (
        .clk   (clk),
        .we    (phase_q == PH_SCHED),
        .waddr (cnt_q),
        .wdata (k_next),
        .raddr (rk_raddr),
        .rdata (rk_rd)
    );

    // Phase sequencing, step counter, result capture and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            cnt_q    <= '0;
            dec_q    <= 1'b0;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        dec_q   <= decrypt_i;
                        cnt_q   <= '0;
                        phase_q <= PH_SCHED;
                    end
                end
                PH_SCHED: begin
                    cnt_q <= last_step ? '0 : cnt_q + 1'b1;
                    if (last_step) phase_q <= PH_ROUND;
                end
                PH_ROUND: begin
                    if (last_step) begin
                        result_q <= {x_next, xwin_q[3], xwin_q[2], xwin_q[1]};
                        done_q   <= 1'b1;
                        cnt_q    <= '0;
                        phase_q  <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Word windows: load on accept, shift one word per step in each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                kwin_q[w] <= '0;
                xwin_q[w] <= '0;
            end
        end else if (accept) begin
            for (int w = 0; w < WORDS; w++) begin
                kwin_q[w] <= key_i[BLOCK_W-1-w*WORD_W -: WORD_W] ^ fk_word(w);
                xwin_q[w] <= block_i[BLOCK_W-1-w*WORD_W -: WORD_W];
            end
        end else if (phase_q == PH_SCHED) begin
            kwin_q[0] <= kwin_q[1];
            kwin_q[1] <= kwin_q[2];
            kwin_q[2] <= kwin_q[3];
            kwin_q[3] <= k_next;
        end else if (phase_q == PH_ROUND) begin
            xwin_q[0] <= xwin_q[1];
            xwin_q[1] <= xwin_q[2];
            xwin_q[2] <= xwin_q[3];
            xwin_q[3] <= x_next;
        end
    end

    assign busy_o   = (phase_q != PH_IDLE);
    assign done_o   = done_q;
    assign result_o = result_q;

endmodule

// File: rtl/sm4_iter_core_chk.sv
// Protocol checker for sm4_iter_core: latency, pulse shape, busy window,
// result hold and reset state. Bound to every instance of the core.
module sm4_iter_core_chk #(
    parameter int ROUNDS = 32
)
(
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [127:0] result_o
);

    localparam int LAT   = 2 * ROUNDS;
    localparam int LAT_W = $clog2(LAT + 1) + 1;

    logic             run_q;
    logic [LAT_W-1:0] lat_q;

    // Track cycles elapsed since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            lat_q <= '0;
        end else if (start_i && !busy_o) begin
            run_q <= 1'b1;
            lat_q <= '0;
        end else if (done_o) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && result_o == '0));

    // R6
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && lat_q < LAT_W'(LAT)) |-> busy_o);

    // R7
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_q && lat_q == LAT_W'(LAT)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

endmodule

bind sm4_iter_core sm4_iter_core_chk #(.ROUNDS(ROUNDS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/sm4_iter_core_tb_top.sv
// Scoreboard bench: a driver pushes expected results, a monitor pops and
// compares them when done_o pulses. Expected values come from a published
// vector and an independent behavioural model.
module sm4_iter_core_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         dec = 1'b0;
    logic [127:0] key = '0;
    logic [127:0] blk = '0;
    logic         busy;
    logic         done;
    logic [127:0] result;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    typedef struct {
        logic [127:0] exp;
        int           t0;
        string        tag;
    } item_t;

    item_t      sb_q [$];
    logic [7:0] tb_sbox [256];

    localparam logic [127:0] STD_KEY = 128'h0123456789abcdeffedcba9876543210;
    localparam logic [127:0] STD_CT  = 128'h681edf34d206965e86b3e94f536e4246;

    sm4_iter_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .decrypt_i (dec),
        .key_i     (key),
        .block_i   (blk),
        .busy_o    (busy),
        .done_o    (done),
        .result_o  (result)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] p;
        logic [7:0] r;
        r = 8'h00;
        p = {1'b0, a};
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ p[7:0];
            p = {p[7:0], 1'b0};
            if (p[8]) p = p ^ 9'h1F5;
        end
        return r;
    endfunction

    function automatic logic [7:0] m_aff(input logic [7:0] v);
        logic [7:0] row;
        logic [7:0] o;
        row = 8'hA7;
        for (int r = 0; r < 8; r++) begin
            o[r] = ^(v & row);
            row = {row[6:0], row[7]};
        end
        return o ^ 8'hD3;
    endfunction

    function automatic logic [31:0] m_tau(input logic [31:0] a);
        return {tb_sbox[a[31:24]], tb_sbox[a[23:16]], tb_sbox[a[15:8]], tb_sbox[a[7:0]]};
    endfunction

    function automatic logic [127:0] m_cipher(input logic [127:0] k,
                                              input logic [127:0] b,
                                              input logic d);
        logic [31:0] kk [36];
        logic [31:0] xx [36];
        logic [31:0] rk [32];
        logic [31:0] t;
        logic [31:0] ck;
        kk[0] = k[127:96] ^ 32'hA3B1BAC6;
        kk[1] = k[95:64]  ^ 32'h56AA3350;
        kk[2] = k[63:32]  ^ 32'h677D9197;
        kk[3] = k[31:0]   ^ 32'hB27022DC;
        for (int i = 0; i < 32; i++) begin
            ck = {8'((4*i)*7), 8'((4*i+1)*7), 8'((4*i+2)*7), 8'((4*i+3)*7)};
            t = m_tau(kk[i+1] ^ kk[i+2] ^ kk[i+3] ^ ck);
            kk[i+4] = kk[i] ^ t ^ {t[18:0], t[31:19]} ^ {t[8:0], t[31:9]};
            rk[i] = kk[i+4];
        end
        xx[0] = b[127:96];
        xx[1] = b[95:64];
        xx[2] = b[63:32];
        xx[3] = b[31:0];
        for (int i = 0; i < 32; i++) begin
            t = m_tau(xx[i+1] ^ xx[i+2] ^ xx[i+3] ^ (d ? rk[31-i] : rk[i]));
            xx[i+4] = xx[i] ^ t ^ {t[29:0], t[31:30]} ^ {t[21:0], t[31:22]}
                            ^ {t[13:0], t[31:14]} ^ {t[7:0], t[31:8]};
        end
        return {xx[35], xx[34], xx[33], xx[32]};
    endfunction

    // ---------------- driver ----------------
    task automatic issue(input logic [127:0] k, input logic [127:0] b,
                         input logic d, input logic [127:0] e, input string tag);
        item_t it;
        key = k;
        blk = b;
        dec = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R6 busy after accepted start", {127'd0, busy}, 128'd1);
        it.exp = e;
        it.t0  = cyc;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // ---------------- monitor ----------------
    initial begin
        bit pend_pw;
        item_t it;
        pend_pw = 1'b0;
        forever begin
            @(negedge clk);
            if (pend_pw) begin
                chk(done == 1'b0, "R7 done pulse width", {127'd0, done}, 128'd0);
                pend_pw = 1'b0;
            end
            if (rst_n && done) begin
                pend_pw = 1'b1;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R8 done with no accepted start", result, '0);
                end else begin
                    it = sb_q.pop_front();
                    chk(result == it.exp, it.tag, result, it.exp);
                    chk(cyc == it.t0 + 64, "R7 done latency",
                        128'(cyc), 128'(it.t0 + 64));
                    chk(busy == 1'b0, "R7 busy low with done", {127'd0, busy}, 128'd0);
                end
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R7 watchdog expired actual=busy expected=idle");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [127:0] pt;
        logic [127:0] ct;
        logic [127:0] k;

        for (int x = 0; x < 256; x++) begin
            logic [7:0] a;
            logic [7:0] iv;
            a = m_aff(8'(x));
            iv = 8'h00;
            for (int y = 1; y < 256; y++)
                if (m_mul(a, 8'(y)) == 8'h01) iv = 8'(y);
            tb_sbox[x] = m_aff(iv);
        end

        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R1 reset busy", {127'd0, busy}, '0);
        chk(done == 1'b0, "R1 reset done", {127'd0, done}, '0);
        chk(result == '0, "R1 reset result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Published vector, encrypt then decrypt.
        issue(STD_KEY, STD_KEY, 1'b0, STD_CT, "R2 R3 R4 standard encrypt vector");
        wait_idle();
        issue(STD_KEY, STD_CT, 1'b1, STD_KEY, "R5 standard decrypt vector");
        wait_idle();

        // R10: result holds while inputs move and no start is given.
        key = ~key;
        blk = 128'h5555;
        repeat (20) @(negedge clk);
        chk(result == STD_KEY, "R10 result holds while idle", result, STD_KEY);

        // Boundary patterns.
        issue('0, '0, 1'b0, m_cipher('0, '0, 1'b0), "R2 R4 all-zero key and block");
        wait_idle();
        issue('1, '1, 1'b0, m_cipher('1, '1, 1'b0), "R3 R4 all-one key and block");
        wait_idle();
        issue('1, '0, 1'b1, m_cipher('1, '0, 1'b1), "R5 all-one key decrypt");
        wait_idle();

        // Varied keys: encrypt, then decrypt back to plaintext.
        for (int i = 0; i < 6; i++) begin
            k  = {4{32'h9E3779B9 * (i + 1)}} ^ {32'(i), 32'hC0FFEE00, 32'(i * 77), 32'h1};
            pt = {32'h0BADF00D ^ 32'(i), 32'h76543210, 32'(i * 1013), 32'hFEEDFACE};
            ct = m_cipher(k, pt, 1'b0);
            issue(k, pt, 1'b0, ct, "R2 R3 varied key encrypt");
            wait_idle();
            issue(k, ct, 1'b1, pt, "R5 varied key decrypt roundtrip");
            wait_idle();
        end

        // R8 and R9: start and input changes during a run are ignored.
        pt = 128'h00112233445566778899aabbccddeeff;
        ct = m_cipher(STD_KEY, pt, 1'b0);
        issue(STD_KEY, pt, 1'b0, ct, "R8 R9 result with mid-run start and input change");
        repeat (10) @(negedge clk);
        key = '1;
        blk = '0;
        dec = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (70) @(negedge clk);
        chk(busy == 1'b0, "R8 no run from ignored start", {127'd0, busy}, '0);
        chk(result == ct, "R8 result kept after ignored start", result, ct);

        // R11: back-to-back starts in the done cycle.
        pt = 128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D;
        k  = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
        issue(k, pt, 1'b0, m_cipher(k, pt, 1'b0), "R11 first back-to-back block");
        while (!done) @(negedge clk);
        issue(k, m_cipher(k, pt, 1'b0), 1'b1, pt, "R11 second block started on done");
        wait_idle();

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R7 all expected results delivered",
            128'(sb_q.size()), '0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule